// File: doc/BRIEF.md
# Charge-Balance Injection Pulse Controller

This block is the digital half of a charge-balancing current-to-frequency converter. An analog integrator accumulates an input current. When its output crosses a threshold, an asynchronous comparator output goes high. The block responds with one fixed-size charge packet. It drives a charge phase and a discharge phase of a switched-capacitor injector. The phases are separated by dead time, and each lasts a programmable number of clock cycles.

While an external measurement window is high, every injection is counted. When the window falls, the count is frozen into a result register, where the host can read it at leisure. The measured current is proportional to the counted packets divided by the window length.

Injections continue whether the window is open or not, so the integrator stays balanced between measurements. A sticky flag marks a window whose count would not fit in the counter.

Top module: `cbc_pulse_ctrl`

## Requirements
- R1: The running count is cleared when the window opens. It advances by one for each injection accepted while the window is high, and does not change while the window is low.
- R2: When the window closes, the running count is copied into `count_o`. `count_o` then keeps that value until the next window closes.
- R3: The count is 12 bits wide and saturates at 4095. An injection accepted at 4095 sets `ovf_o`, which stays set until the next window opens. Exactly 4095 injections leave the flag clear.
- R4: A low-to-high transition of `comp_i`, seen by the block while it is idle, starts one injection. `mono_o` is high from the first charge cycle to the last discharge cycle inclusive, that is 2·L+2 cycles for a phase length of L.
- R5: `dly_code_i` sets the phase length L in clock cycles: 0 gives 70, 1 gives 87, 2 gives 100 and 3 gives 120. The charge phase and the discharge phase each last L cycles.
- R6: `phi_chg_o` and `phi_dis_o` are never high together. Exactly 2 cycles with both low separate the end of the charge phase from the start of the discharge phase, and at least 2 follow the discharge phase.
- R7: A `comp_i` rising transition that arrives while an injection is in progress is ignored. It produces no second charge phase and no extra count.
- R8: After reset, both phases, `mono_o`, `count_o` and `ovf_o` are 0.
- R9: Crossings that occur while the window is low still produce full injections, but are not counted.
- R10: The delay code is captured when an injection starts. Changing it during the injection alters neither phase of that injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (100 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Asynchronous comparator output, high at threshold crossing |
| win_i | input | 1 | Asynchronous measurement window, high while measuring |
| dly_code_i | input | 2 | Phase length select code |
| phi_chg_o | output | 1 | Charge-phase switch control |
| phi_dis_o | output | 1 | Discharge-phase switch control |
| mono_o | output | 1 | Monostable pulse covering the whole injection |
| count_o | output | 12 | Count latched at the last window close |
| ovf_o | output | 1 | Sticky overflow of the running count |

## Verification
The hardest condition to reach is counter saturation. It needs more than four thousand accepted injections inside one window. With the nominal phase lengths, that would take far more cycles than the run allows.

The bench therefore adds a second instance whose four phase lengths are set to 2 cycles. Comparator pulses are spaced just beyond that instance's lockout. The bench then runs one window with exactly 4095 crossings and one with 4097. This places both sides of the saturation boundary and the flag clearing within reach.

Lockout is reached by raising the comparator a second time in the middle of a charge phase.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHG,
    ST_GAP1,
    ST_DIS,
    ST_GAP2
  } inj_state_e;

  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cbc_inject_seq.sv
module cbc_inject_seq
  import cbc_pkg::*;
#(
  parameter int unsigned LEN0    = 70,
  parameter int unsigned LEN1    = 87,
  parameter int unsigned LEN2    = 100,
  parameter int unsigned LEN3    = 120,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              comp_s_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fire_o,
  output logic              phi_chg_o,
  output logic              phi_dis_o,
  output logic              mono_o
);
  localparam int unsigned MAX01 = (LEN0 > LEN1) ? LEN0 : LEN1;
  localparam int unsigned MAX23 = (LEN2 > LEN3) ? LEN2 : LEN3;
  localparam int unsigned MAXL  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned MAXT  = (MAXL > GAP_CYC) ? MAXL : GAP_CYC;
  localparam int unsigned TW    = $clog2(MAXT + 1);

  inj_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] len_q, len_d;
  logic [TW-1:0] len_sel;
  logic          comp_q;
  logic          rise;

  always_comb begin
    unique case (code_i)
      2'd0:    len_sel = TW'(LEN0);
      2'd1:    len_sel = TW'(LEN1);
      2'd2:    len_sel = TW'(LEN2);
      default: len_sel = TW'(LEN3);
    endcase
  end

  assign rise   = comp_s_i & ~comp_q;
  assign fire_o = (st_q == ST_IDLE) & rise;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    len_d = len_q;
    unique case (st_q)
      ST_IDLE: if (rise) begin
        st_d  = ST_CHG;
        len_d = len_sel;
        tmr_d = len_sel - TW'(1);
      end
      ST_CHG: if (tmr_q == '0) begin
        st_d  = ST_GAP1;
        tmr_d = TW'(GAP_CYC - 1);
      end else tmr_d = tmr_q - TW'(1);
      ST_GAP1: if (tmr_q == '0) begin
        st_d  = ST_DIS;
        tmr_d = len_q - TW'(1);
      end else tmr_d = tmr_q - TW'(1);
      ST_DIS: if (tmr_q == '0) begin
        st_d  = ST_GAP2;
        tmr_d = TW'(GAP_CYC - 1);
      end else tmr_d = tmr_q - TW'(1);
      ST_GAP2: if (tmr_q == '0) st_d = ST_IDLE;
               else tmr_d = tmr_q - TW'(1);
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      len_q  <= '0;
      comp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      len_q  <= len_d;
      comp_q <= comp_s_i;
    end
  end

  assign phi_chg_o = (st_q == ST_CHG);
  assign phi_dis_o = (st_q == ST_DIS);
  assign mono_o    = (st_q == ST_CHG) | (st_q == ST_GAP1) | (st_q == ST_DIS);

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi_chg_o && phi_dis_o)); // R6
  AST_DEAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi_chg_o) |-> !phi_dis_o); // R6
  AST_DEAD_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi_chg_o) |=> !phi_dis_o); // R6
  AST_DIS_THEN_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi_dis_o) |-> !phi_chg_o); // R6
  AST_CHG_ONLY_FROM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi_chg_o) |-> $past(fire_o)); // R4
endmodule

// File: rtl/cbc_win_counter.sv
module cbc_win_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_s_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] res_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, res_q;
  logic             ovf_q, win_q;
  logic             win_rise, win_fall;

  assign win_rise = win_s_i & ~win_q;
  assign win_fall = ~win_s_i & win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
      win_q <= 1'b0;
    end else begin
      win_q <= win_s_i;
      if (win_rise) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (win_s_i && inc_i) begin
        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                  cnt_q <= cnt_q + 1'b1;
      end
      if (win_fall) res_q <= cnt_q;
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;

  AST_NO_COUNT_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_s_i |=> $stable(cnt_q)); // R1
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && win_s_i && inc_i && !win_rise) |=> (cnt_q == CNT_MAX && ovf_q)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !win_rise) |=> ovf_q); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_fall |=> $stable(res_q)); // R2
endmodule

// File: rtl/cbc_pulse_ctrl.sv
module cbc_pulse_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned LEN0    = 70,
  parameter int unsigned LEN1    = 87,
  parameter int unsigned LEN2    = 100,
  parameter int unsigned LEN3    = 120,
  parameter int unsigned GAP_CYC = 2,
  parameter int unsigned CNT_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             comp_i,
  input  logic             win_i,
  input  logic [1:0]       dly_code_i,
  output logic             phi_chg_o,
  output logic             phi_dis_o,
  output logic             mono_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [1:0] async_in, sync_out;
  logic       fire;

  assign async_in = {win_i, comp_i};

  cbc_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in),
    .q_o    (sync_out)
  );

  cbc_inject_seq #(
    .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .comp_s_i  (sync_out[0]),
    .code_i    (dly_code_i),
    .fire_o    (fire),
    .phi_chg_o (phi_chg_o),
    .phi_dis_o (phi_dis_o),
    .mono_o    (mono_o)
  );

  cbc_win_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .win_s_i (sync_out[1]),
    .inc_i   (fire),
    .res_o   (count_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: tb/cbc_pulse_ctrl_tb.sv
module cbc_pulse_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp = 1'b0, win = 1'b0;
  logic [1:0]  code = 2'd0;
  logic        phi_chg, phi_dis, mono, ovf;
  logic [11:0] count;
  logic        comp2 = 1'b0, win2 = 1'b0;
  logic        phi_chg2, phi_dis2, mono2, ovf2;
  logic [11:0] count2;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int exp_q[$];
  event win_closed;

  always #2 clk = ~clk;

  cbc_pulse_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp), .win_i(win), .dly_code_i(code),
    .phi_chg_o(phi_chg), .phi_dis_o(phi_dis), .mono_o(mono),
    .count_o(count), .ovf_o(ovf)
  );

  cbc_pulse_ctrl #(.LEN0(2), .LEN1(2), .LEN2(2), .LEN3(2)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp2), .win_i(win2), .dly_code_i(2'd0),
    .phi_chg_o(phi_chg2), .phi_dis_o(phi_dis2), .mono_o(mono2),
    .count_o(count2), .ovf_o(ovf2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected window counts and compares with the latched result
  initial begin
    forever begin
      @(win_closed);
      if (exp_q.size() == 0) check(1'b0, "R2 queue", 0, 1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(count == 12'(e), "R1/R2 window count", int'(count), e);
      end
    end
  end

  task automatic shot(input logic [1:0] c, input int swap_at, input int second_at,
                      output int lc, output int ld, output int lg, output int lm,
                      output int nchg, output int novl);
    logic pc;
    bit   fell, dis_seen;
    lc = 0; ld = 0; lg = 0; lm = 0; nchg = 0; novl = 0;
    pc = 1'b0; fell = 1'b0; dis_seen = 1'b0;
    code = c;
    for (int i = 0; i < 700; i++) begin
      comp = (i < 3) || (second_at >= 0 && i >= second_at && i < second_at + 3);
      if (i == swap_at) code = ~c;
      @(negedge clk);
      if (phi_chg) lc++;
      if (phi_dis) ld++;
      if (mono) lm++;
      if (phi_chg && phi_dis) novl++;
      if (phi_chg && !pc) nchg++;
      if (pc && !phi_chg) fell = 1'b1;
      if (phi_dis) dis_seen = 1'b1;
      if (fell && !dis_seen && !phi_chg && !phi_dis) lg++;
      pc = phi_chg;
    end
    comp = 1'b0;
  endtask

  task automatic open_win();
    win = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic close_win(input int exp);
    win = 1'b0;
    exp_q.push_back(exp);
    repeat (8) @(negedge clk);
    -> win_closed;
    @(negedge clk);
  endtask

  task automatic sat_window(input int n);
    win2 = 1'b1;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      comp2 = 1'b1;
      repeat (2) @(negedge clk);
      comp2 = 1'b0;
      repeat (10) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    win2 = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int lc, ld, lg, lm, nchg, novl;
    int lens[4];
    lens = '{70, 87, 100, 120};
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!phi_chg && !phi_dis && !mono, "R8 phases idle", int'({phi_chg, phi_dis, mono}), 0);
    check(count == 0, "R8 count", int'(count), 0);
    check(ovf == 0, "R8 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 R5 R6: pulse shape per code
    for (int k = 0; k < 4; k++) begin
      shot(2'(k), -1, -1, lc, ld, lg, lm, nchg, novl);
      check(lc == lens[k], "R5 charge length", lc, lens[k]);
      check(ld == lens[k], "R5 discharge length", ld, lens[k]);
      check(lg == 2, "R6 dead time", lg, 2);
      check(novl == 0, "R6 overlap", novl, 0);
      check(lm == 2 * lens[k] + 2, "R4 mono length", lm, 2 * lens[k] + 2);
      check(nchg == 1, "R4 one injection", nchg, 1);
    end

    // R10: code change mid-pulse
    shot(2'd1, 20, -1, lc, ld, lg, lm, nchg, novl);
    check(lc == 87, "R10 charge keeps code", lc, 87);
    check(ld == 87, "R10 discharge keeps code", ld, 87);
    code = 2'd2;

    // R1: three counted injections
    open_win();
    for (int k = 0; k < 3; k++) shot(2'd2, -1, -1, lc, ld, lg, lm, nchg, novl);
    close_win(3);

    // R7: second crossing during charge is ignored
    open_win();
    shot(2'd0, -1, 30, lc, ld, lg, lm, nchg, novl);
    check(nchg == 1, "R7 lockout single charge", nchg, 1);
    close_win(1);

    // R9 and R2: injections with window closed, result holds
    shot(2'd0, -1, -1, lc, ld, lg, lm, nchg, novl);
    check(nchg == 1 && ld == 70, "R9 injection while closed", nchg, 1);
    check(count == 1, "R2 result holds", int'(count), 1);

    // R1: empty window clears count
    open_win();
    close_win(0);
    open_win();
    for (int k = 0; k < 5; k++) shot(2'd3, -1, -1, lc, ld, lg, lm, nchg, novl);
    close_win(5);

    // R3: saturation boundary on the short-phase instance
    sat_window(4095);
    check(count2 == 12'd4095, "R3 exact full count", int'(count2), 4095);
    check(ovf2 == 1'b0, "R3 no ovf at 4095", int'(ovf2), 0);
    sat_window(4097);
    check(count2 == 12'd4095, "R3 saturated count", int'(count2), 4095);
    check(ovf2 == 1'b1, "R3 ovf set", int'(ovf2), 1);
    win2 = 1'b1;
    repeat (8) @(negedge clk);
    check(ovf2 == 1'b0, "R3 ovf cleared on open", int'(ovf2), 0);
    win2 = 1'b0;
    repeat (8) @(negedge clk);
    check(count2 == 12'd0, "R1 cleared on open", int'(count2), 0);

    check(exp_q.size() == 0, "R2 all windows compared", exp_q.size(), 0);
    summary();
  end
endmodule